// File: doc/BRIEF.md
# Priority-Interleaved Link Frame Multiplexer

This block assembles the character stream for one serial readout line. Every clock cycle it hands one 8-bit character and a control-character flag to a downstream 8b/10b encoder. At 400 Mb/s with 10-bit coding this is exactly one character per 40 MHz crossing clock. Three sources compete for the line, each through a valid/ready handshake:
- **Readout data words** from an acquisition FIFO. These go out in framed groups.
- **Urgent hit-address records.** These have the highest priority.
- **Configuration or control replies.** These have the lowest priority.

An urgent record can be spliced into a data frame that is already on the wire, at any character boundary. The frame then carries on with its next unsent word and sends no new header, so no data is lost or repeated.

Configuration traffic goes out only while no urgent record is waiting and no data frame is open. When nothing can be sent, a dedicated idle control character fills the slot. A source must hold its valid signal and its character stable until ready is seen. A character is consumed on a clock edge where both valid and ready are high, and it appears on the output in the cycle after that edge.

Top module: `link_frame_mux`

## Requirements
- R1: A data frame is the control character 0x3C (tx_is_k=1), then exactly FRAME_LEN (default 4) data characters (tx_is_k=0) in FIFO order. fifo_ready is high only in a cycle whose edge emits a data character. The popped word appears on tx_char in the next cycle.
- R2: An urgent record is the control character 0x5C, then one address character with tx_is_k=0. hit_ready is high only in the cycle whose edge emits that address character.
- R3: When hit_valid is high and no record byte is owed (address or configuration byte), the next output is 0x5C. This holds even between two data characters of an open frame.
- R4: After an urgent record inside an open frame, the frame continues with its next unsent word and no new 0x3C header.
- R5: A configuration record is the control character 0x7C, then one configuration character with tx_is_k=0. It starts only while hit_valid is low and no data frame is open. It is atomic: an urgent record that arrives after the 0x7C waits until the configuration character has been sent.
- R6: When no source can send, the output is the idle character 0xBC with tx_is_k=1. This includes an open frame whose FIFO is empty. No configuration record starts inside such a gap.
- R7: Urgent records that arrive back to back are all sent before a waiting data frame starts. Urgent records and data then reach the receiver complete and in order under any mix of traffic.
- R8: Synchronous active-high reset: while rst is high, the output is 0xBC with tx_is_k=1 and every ready is low. After reset, no frame is open.
- R9: At most one of fifo_ready, hit_ready and cfg_ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one character per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fifo_valid | input | 1 | Readout FIFO has a word |
| fifo_word | input | 8 | Head word of the readout FIFO |
| fifo_ready | output | 1 | Head word is emitted at this edge (pop) |
| hit_valid | input | 1 | Urgent hit-address record waiting |
| hit_addr | input | 8 | Address character of the urgent record |
| hit_ready | output | 1 | Address character is emitted at this edge |
| cfg_valid | input | 1 | Configuration reply byte waiting |
| cfg_byte | input | 8 | Configuration reply byte |
| cfg_ready | output | 1 | Configuration byte is emitted at this edge |
| tx_char | output | 8 | Character to the 8b/10b encoder |
| tx_is_k | output | 1 | tx_char is a control character |

## Verification
The hardest situation to reach from the ports is an urgent record that lands at one exact character position: between two particular data words of an open frame, or just after a configuration header. The bench gets there by watching the captured output stream. It raises hit_valid in the same falling-edge slot in which it logs a chosen character, so the record meets the frame or the configuration record at exactly that boundary. A long random mix of all three sources then runs. An independent receiver model decodes the logged stream and checks that every data word, address and configuration byte arrives once and in order, and that frames are well formed.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    // What is owed after a header character has been sent
    typedef enum logic [1:0] {
        PH_FREE     = 2'd0,
        PH_HIT_ADDR = 2'd1,
        PH_CFG_BYTE = 2'd2
    } phase_e;

    // Decision for the character emitted at the coming edge
    typedef enum logic [2:0] {
        G_IDLE      = 3'd0,
        G_HIT_HDR   = 3'd1,
        G_HIT_ADDR  = 3'd2,
        G_CFG_HDR   = 3'd3,
        G_CFG_BYTE  = 3'd4,
        G_DATA_HDR  = 3'd5,
        G_DATA_WORD = 3'd6,
        G_GAP       = 3'd7
    } grant_e;

endpackage

// File: rtl/lfm_arbiter.sv
module lfm_arbiter
    import lfm_pkg::*;
(
    input  phase_e phase,
    input  logic   frame_open,
    input  logic   hit_valid,
    input  logic   fifo_valid,
    input  logic   cfg_valid,
    output grant_e grant
);

    // Owed record bytes first, then urgent, then open frame, then new frame,
    // then configuration, then idle.
    always_comb begin
        if (phase == PH_HIT_ADDR) begin
            grant = G_HIT_ADDR;
        end else if (phase == PH_CFG_BYTE) begin
            grant = G_CFG_BYTE;
        end else if (hit_valid) begin
            grant = G_HIT_HDR;
        end else if (frame_open) begin
            grant = fifo_valid ? G_DATA_WORD : G_GAP;
        end else if (fifo_valid) begin
            grant = G_DATA_HDR;
        end else if (cfg_valid) begin
            grant = G_CFG_HDR;
        end else begin
            grant = G_IDLE;
        end
    end

endmodule

// File: rtl/lfm_char_sel.sv
module lfm_char_sel
    import lfm_pkg::*;
#(
    parameter int          W      = 8,
    parameter logic [W-1:0] K_DATA = 8'h3C,
    parameter logic [W-1:0] K_HIT  = 8'h5C,
    parameter logic [W-1:0] K_CFG  = 8'h7C,
    parameter logic [W-1:0] K_IDLE = 8'hBC
) (
    input  grant_e       grant,
    input  logic [W-1:0] fifo_word,
    input  logic [W-1:0] hit_addr,
    input  logic [W-1:0] cfg_byte,
    output logic [W-1:0] ch,
    output logic         is_k
);

    always_comb begin
        ch   = K_IDLE;
        is_k = 1'b1;
        unique case (grant)
            G_HIT_HDR:   ch = K_HIT;
            G_CFG_HDR:   ch = K_CFG;
            G_DATA_HDR:  ch = K_DATA;
            G_HIT_ADDR:  begin ch = hit_addr;  is_k = 1'b0; end
            G_CFG_BYTE:  begin ch = cfg_byte;  is_k = 1'b0; end
            G_DATA_WORD: begin ch = fifo_word; is_k = 1'b0; end
            G_IDLE, G_GAP: ch = K_IDLE;
        endcase
    end

endmodule

// File: rtl/link_frame_mux.sv
module link_frame_mux
    import lfm_pkg::*;
#(
    parameter int          W         = 8,
    parameter int          FRAME_LEN = 4,
    parameter logic [W-1:0] K_DATA    = 8'h3C,
    parameter logic [W-1:0] K_HIT     = 8'h5C,
    parameter logic [W-1:0] K_CFG     = 8'h7C,
    parameter logic [W-1:0] K_IDLE    = 8'hBC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fifo_valid,
    input  logic [W-1:0] fifo_word,
    output logic         fifo_ready,
    input  logic         hit_valid,
    input  logic [W-1:0] hit_addr,
    output logic         hit_ready,
    input  logic         cfg_valid,
    input  logic [W-1:0] cfg_byte,
    output logic         cfg_ready,
    output logic [W-1:0] tx_char,
    output logic         tx_is_k
);

    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        phase_e          phase;
        logic            frame_open;
        logic [CNT_W-1:0] sent;
        logic [W-1:0]    ch;
        logic            is_k;
    } st_t;

    st_t st_d, st_q;

    grant_e       grant;
    logic [W-1:0] sel_ch;
    logic         sel_k;

    lfm_arbiter u_arb (
        .phase      (st_q.phase),
        .frame_open (st_q.frame_open),
        .hit_valid  (hit_valid),
        .fifo_valid (fifo_valid),
        .cfg_valid  (cfg_valid),
        .grant      (grant)
    );

    lfm_char_sel #(
        .W      (W),
        .K_DATA (K_DATA),
        .K_HIT  (K_HIT),
        .K_CFG  (K_CFG),
        .K_IDLE (K_IDLE)
    ) u_sel (
        .grant     (grant),
        .fifo_word (fifo_word),
        .hit_addr  (hit_addr),
        .cfg_byte  (cfg_byte),
        .ch        (sel_ch),
        .is_k      (sel_k)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ch   = sel_ch;
        st_d.is_k = sel_k;
        unique case (grant)
            G_HIT_HDR:  st_d.phase = PH_HIT_ADDR;
            G_CFG_HDR:  st_d.phase = PH_CFG_BYTE;
            G_HIT_ADDR, G_CFG_BYTE: st_d.phase = PH_FREE;
            G_DATA_HDR: begin
                st_d.frame_open = 1'b1;
                st_d.sent       = '0;
            end
            G_DATA_WORD: begin
                if (st_q.sent == LAST_SLOT) begin
                    st_d.frame_open = 1'b0;
                    st_d.sent       = '0;
                end else begin
                    st_d.sent = st_q.sent + 1'b1;
                end
            end
            G_IDLE, G_GAP: ;
        endcase
        if (rst) begin
            st_d.phase      = PH_FREE;
            st_d.frame_open = 1'b0;
            st_d.sent       = '0;
            st_d.ch         = K_IDLE;
            st_d.is_k       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fifo_ready = !rst && (grant == G_DATA_WORD);
    assign hit_ready  = !rst && (grant == G_HIT_ADDR);
    assign cfg_ready  = !rst && (grant == G_CFG_BYTE);
    assign tx_char    = st_q.ch;
    assign tx_is_k    = st_q.is_k;

    // R1: a popped word shows up as a plain character one cycle later
    p_pop_emits_word_r1: assert property (@(posedge clk) disable iff (rst)
        (fifo_ready && fifo_valid) |=> (!tx_is_k && tx_char == $past(fifo_word)));

    // R2: the address is taken only right after the urgent header was sent
    p_addr_after_hdr_r2: assert property (@(posedge clk) disable iff (rst)
        hit_ready |-> (tx_is_k && tx_char == K_HIT));

    // R3: a waiting urgent record with nothing owed goes out next
    p_hit_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && st_q.phase == PH_FREE) |=> (tx_is_k && tx_char == K_HIT));

    // R5: configuration header never leaves inside an open frame
    p_cfg_outside_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_valid || st_q.frame_open) |=> !(tx_is_k && tx_char == K_CFG));

    // R9: one pop at most per cycle
    p_single_ready_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_ready, hit_ready, cfg_ready}));

    // R1: a frame header is never sent while a frame is already open
    p_no_nested_hdr_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.frame_open && st_q.phase == PH_FREE && !hit_valid)
            |=> !(tx_is_k && tx_char == K_DATA));

endmodule

// File: tb/link_frame_mux_bench.sv
module link_frame_mux_bench;

    localparam logic [8:0] KD = 9'h13C;
    localparam logic [8:0] KA = 9'h15C;
    localparam logic [8:0] KC = 9'h17C;
    localparam logic [8:0] KI = 9'h1BC;
    localparam int FLEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_valid = 1'b0, hit_valid = 1'b0, cfg_valid = 1'b0;
    logic [7:0] fifo_word = '0, hit_addr = '0, cfg_byte = '0;
    logic       fifo_ready, hit_ready, cfg_ready;
    logic [7:0] tx_char;
    logic       tx_is_k;

    always #2 clk = ~clk;

    link_frame_mux u_link_frame_mux (
        .clk(clk), .rst(rst),
        .fifo_valid(fifo_valid), .fifo_word(fifo_word), .fifo_ready(fifo_ready),
        .hit_valid(hit_valid), .hit_addr(hit_addr), .hit_ready(hit_ready),
        .cfg_valid(cfg_valid), .cfg_byte(cfg_byte), .cfg_ready(cfg_ready),
        .tx_char(tx_char), .tx_is_k(tx_is_k)
    );

    logic [7:0] dq[$], aq[$], cq[$];
    logic [7:0] sent_d[$], sent_a[$], sent_c[$];
    logic [8:0] lg[$];
    logic       cap = 1'b0;
    logic       trig_en = 1'b0;
    logic [8:0] trig_val = '0;
    logic [7:0] trig_addr = '0;
    logic       pd = 0, pa = 0, pc = 0;
    int         n_tests = 0, n_fail = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Falling-edge driver: retire pops, log output, drive sources, sample readys
    always @(negedge clk) begin
        if (pd) void'(dq.pop_front());
        if (pa) void'(aq.pop_front());
        if (pc) void'(cq.pop_front());
        if (cap) begin
            lg.push_back({tx_is_k, tx_char});
            if (trig_en && {tx_is_k, tx_char} == trig_val) begin
                aq.push_back(trig_addr);
                trig_en = 1'b0;
            end
        end
        fifo_valid = dq.size() > 0;  fifo_word = fifo_valid ? dq[0] : 8'h00;
        hit_valid  = aq.size() > 0;  hit_addr  = hit_valid  ? aq[0] : 8'h00;
        cfg_valid  = cq.size() > 0;  cfg_byte  = cfg_valid  ? cq[0] : 8'h00;
        #1;
        pd = fifo_ready && fifo_valid;
        pa = hit_ready && hit_valid;
        pc = cfg_ready && cfg_valid;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_seq(input string req, input logic [8:0] exp[]);
        chk(lg.size() >= exp.size(), req, lg.size(), exp.size());
        for (int i = 0; i < exp.size(); i++) begin
            if (i < lg.size()) chk(lg[i] == exp[i], req, lg[i], exp[i]);
        end
    endtask

    task automatic fresh();
        lg.delete();
        cap = 1'b1;
    endtask

    // Independent receiver: decode the logged stream per the requirements
    task automatic parse_and_compare();
        logic [7:0] rd[$], ra[$], rc[$];
        int  owe = 0;  // 1: address owed, 2: config byte owed
        bit  open = 0;
        int  cnt = 0, bad = 0, mism = 0;
        foreach (lg[i]) begin
            if (owe != 0) begin
                if (lg[i][8]) bad++;
                else if (owe == 1) ra.push_back(lg[i][7:0]);
                else rc.push_back(lg[i][7:0]);
                owe = 0;
            end else if (lg[i][8]) begin
                if (lg[i] == KA) owe = 1;
                else if (lg[i] == KC) begin if (open) bad++; owe = 2; end
                else if (lg[i] == KD) begin if (open) bad++; open = 1; cnt = 0; end
                else if (lg[i] != KI) bad++;
            end else begin
                if (!open) bad++;
                rd.push_back(lg[i][7:0]);
                cnt++;
                if (cnt == FLEN) open = 0;
            end
        end
        chk(bad == 0, "R7 stream framing", bad, 0);
        chk(rd.size() == sent_d.size(), "R1 data count", rd.size(), sent_d.size());
        chk(ra.size() == sent_a.size(), "R7 hit count", ra.size(), sent_a.size());
        chk(rc.size() == sent_c.size(), "R5 cfg count", rc.size(), sent_c.size());
        foreach (rd[i]) if (i < sent_d.size() && rd[i] != sent_d[i]) mism++;
        foreach (ra[i]) if (i < sent_a.size() && ra[i] != sent_a[i]) mism++;
        foreach (rc[i]) if (i < sent_c.size() && rc[i] != sent_c[i]) mism++;
        chk(mism == 0, "R4 order and content", mism, 0);
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset with all sources asserting valid
        dq.push_back(8'h99); aq.push_back(8'h98); cq.push_back(8'h97);
        cyc(3);
        chk({tx_is_k, tx_char} == KI, "R8 reset idle", {tx_is_k, tx_char}, KI);
        chk({fifo_ready, hit_ready, cfg_ready} == 3'b000, "R8 readys low",
            {fifo_ready, hit_ready, cfg_ready}, 0);
        dq.delete(); aq.delete(); cq.delete();
        cyc(1);
        rst = 1'b0;
        cyc(1);

        // R6: nothing pending gives idle
        fresh(); cyc(4);
        check_seq("R6 idle fill", '{KI, KI, KI, KI});

        // R1: single frame
        fresh();
        dq.push_back(8'h11); dq.push_back(8'h22); dq.push_back(8'h33); dq.push_back(8'h44);
        cyc(8);
        check_seq("R1 frame", '{KI, KD, 9'h011, 9'h022, 9'h033, 9'h044, KI, KI});

        // R3 R4: urgent record spliced after the first word
        fresh();
        trig_val = 9'h0A0; trig_addr = 8'h77; trig_en = 1'b1;
        dq.push_back(8'hA0); dq.push_back(8'hA1); dq.push_back(8'hA2); dq.push_back(8'hA3);
        cyc(9);
        check_seq("R3 R4 preempt resume",
            '{KI, KD, 9'h0A0, KA, 9'h077, 9'h0A1, 9'h0A2, 9'h0A3, KI});

        // R7 R2: back-to-back urgent records hold off the frame
        fresh();
        aq.push_back(8'h01); aq.push_back(8'h02);
        dq.push_back(8'hD0); dq.push_back(8'hD1); dq.push_back(8'hD2); dq.push_back(8'hD3);
        cyc(11);
        check_seq("R7 R2 back to back",
            '{KI, KA, 9'h001, KA, 9'h002, KD, 9'h0D0, 9'h0D1, 9'h0D2, 9'h0D3, KI});

        // R5: configuration waits for both other sources
        fresh();
        cq.push_back(8'hC1); aq.push_back(8'h09);
        dq.push_back(8'hE0); dq.push_back(8'hE1); dq.push_back(8'hE2); dq.push_back(8'hE3);
        cyc(12);
        check_seq("R5 lowest priority",
            '{KI, KA, 9'h009, KD, 9'h0E0, 9'h0E1, 9'h0E2, 9'h0E3, KC, 9'h0C1, KI, KI});

        // R5: configuration record atomic against a late urgent record
        fresh();
        trig_val = KC; trig_addr = 8'h44; trig_en = 1'b1;
        cq.push_back(8'hC2); cq.push_back(8'hC3);
        cyc(8);
        check_seq("R5 atomic cfg", '{KI, KC, 9'h0C2, KA, 9'h044, KC, 9'h0C3, KI});

        // R6 R4: FIFO underrun inside a frame, config must stay out
        fresh();
        dq.push_back(8'hF0); dq.push_back(8'hF1); cq.push_back(8'hC9);
        cyc(6);
        dq.push_back(8'hF2); dq.push_back(8'hF3);
        cyc(6);
        check_seq("R6 gap in frame",
            '{KI, KD, 9'h0F0, 9'h0F1, KI, KI, KI, 9'h0F2, 9'h0F3, KC, 9'h0C9, KI});

        // R7 R9: random mix of all three sources, decoded by the receiver model
        fresh();
        sent_d.delete(); sent_a.delete(); sent_c.delete();
        void'($urandom(32'h5EED));
        for (int t = 0; t < 4000; t++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 6 && dq.size() < 16) begin
                for (int k = 0; k < FLEN; k++) begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    dq.push_back(v); sent_d.push_back(v);
                end
            end
            r = $urandom_range(0, 99);
            if (r < 12 && aq.size() < 8) begin
                logic [7:0] v;
                v = 8'($urandom);
                aq.push_back(v); sent_a.push_back(v);
            end
            r = $urandom_range(0, 99);
            if (r < 8 && cq.size() < 8) begin
                logic [7:0] v;
                v = 8'($urandom);
                cq.push_back(v); sent_c.push_back(v);
            end
            chk(!(fifo_ready && hit_ready) && !(fifo_ready && cfg_ready) && !(hit_ready && cfg_ready),
                "R9 one ready", {fifo_ready, hit_ready, cfg_ready}, 0);
            cyc(1);
        end
        cyc(400);
        chk(dq.size() == 0 && aq.size() == 0 && cq.size() == 0, "R7 drained",
            dq.size() + aq.size() + cq.size(), 0);
        parse_and_compare();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule